// File: doc/BRIEF.md
# Parallel Bus Master Cycle Engine

This block runs single read and write cycles on an external asynchronous parallel bus as its master. A host loads a 16-bit address register and then presents one request at a time. Each request becomes a complete bus cycle. The cycle drives the address pins, the data lines, two chip-select pins, high and low address-latch strobes, and separate read and write strobes. The address register holds a 14-bit word address in bits 13:0 and two chip-select enables in bits 14 and 15.

A cycle has three programmable phases: setup, then strobe, then hold. In the multiplexed address modes, the address is first presented on the data lines and latched by one or two latch phases. Each latch phase is as long as the setup phase. The data path is 8 or 16 bits wide. After each cycle the address can be held, incremented or decremented. A busy flag covers the whole cycle. When enabled, a one-cycle interrupt marks the end of each cycle. The configuration inputs are expected to stay stable while busy is high.

Top module: `pbus_master`

## Requirements
- R1: The setup phase, and each address-latch phase, lasts cfg_setup+1 clocks (1 to 4).
- R2: The strobe phase lasts cfg_strobe+1 clocks (1 to 16). A read asserts only the read strobe and a write asserts only the write strobe.
- R3: The hold phase after the strobe lasts cfg_hold+1 clocks for a write and cfg_hold clocks for a read, so a read with cfg_hold=0 has no hold phase.
- R4: The address multiplex selector cfg_mux sets what the pins carry:
  - 0: pb_addr carries address[13:0] and there is no latch phase.
  - 1: pb_addr carries {address[13:8], 8'h00}, and the latch phase puts address[7:0] on pb_dout[7:0].
  - 2: pb_addr is zero. The high latch phase puts address[13:8] on pb_dout[7:0], then the low latch phase puts address[7:0] on pb_dout[7:0].
  - 3: pb_addr is zero, and the latch phase puts address[13:0] on pb_dout[15:0].
- R5: cfg_mux=2 runs the high latch strobe phase and then the low latch strobe phase. cfg_mux of 1 or 3 runs only the low latch phase. pb_doe is high during every latch phase.
- R6: With cfg_wide=0 the data path is 8 bits: write data drives pb_dout[7:0] with the upper byte zero, and read data is zero-extended from pb_din[7:0]. With cfg_wide=1 all 16 bits are used. Write data is driven (pb_doe=1) from setup through hold, and read data is sampled at the last strobe clock.
- R7: The end of each cycle updates address bits 13:0 according to cfg_step: 1 increments, 2 decrements, and 0 or 3 holds. The update wraps modulo 2^14 and bits 15:14 are kept. A host load with addr_wr while idle replaces the whole register.
- R8: cfg_csfn selects how the chip-select pins work:
  - 0: pb_cs2 and pb_cs1 drive address bits 15 and 14 at raw level.
  - 1: pb_cs2 is a chip select asserted during a cycle when bit 15 is set, and pb_cs1 is raw bit 14.
  - 2 or 3: both pins are chip selects, enabled by bits 15 and 14.
- R9: Each of the read strobe, write strobe, cs1, cs2 and the two latch strobes is active high when its polarity bit is 1 and active low when it is 0. All of them are inactive while idle.
- R10: A request is accepted only while idle. busy rises at the accepting edge and stays high for exactly the sum of the latch, setup, strobe and hold lengths.
- R11: With cfg_irq_en=1, irq pulses for one clock as busy falls. With cfg_irq_en=0, irq stays low. rd_valid pulses as a read cycle ends, with rd_data holding the sampled value.
- R12: A request while busy starts no cycle and sets err, which stays set until reset. An address load while busy is ignored.
- R13: After reset the block is idle: busy, irq, rd_valid, err, pb_doe and the address register are all 0, and every strobe and chip select sits at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_setup | input | 2 | Setup and latch phase length minus one |
| cfg_strobe | input | 4 | Strobe phase length minus one |
| cfg_hold | input | 2 | Hold length (write: minus one; read: as given) |
| cfg_mux | input | 2 | Address multiplex scheme |
| cfg_wide | input | 1 | 1 = 16-bit data, 0 = 8-bit |
| cfg_step | input | 2 | Address step after a cycle |
| cfg_csfn | input | 2 | Chip-select pin function |
| cfg_pol_rd | input | 1 | Read strobe polarity |
| cfg_pol_wr | input | 1 | Write strobe polarity |
| cfg_pol_cs1 | input | 1 | cs1 polarity |
| cfg_pol_cs2 | input | 1 | cs2 polarity |
| cfg_pol_al | input | 1 | Latch strobe polarity |
| cfg_irq_en | input | 1 | End-of-cycle interrupt enable |
| addr_wr | input | 1 | Load the address register |
| addr_wdata | input | ADDR_W+2 | Address register load value |
| addr_q | output | ADDR_W+2 | Address register |
| req_valid | input | 1 | Cycle request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| rd_data | output | 16 | Last read data |
| rd_valid | output | 1 | Read completion pulse |
| busy | output | 1 | Cycle in progress |
| irq | output | 1 | End-of-cycle interrupt pulse |
| err | output | 1 | Sticky request-while-busy flag |
| pb_addr | output | ADDR_W | Address pins |
| pb_cs1 | output | 1 | Chip select / address bit 14 pin |
| pb_cs2 | output | 1 | Chip select / address bit 15 pin |
| pb_dout | output | 16 | Data lines out |
| pb_doe | output | 1 | Data line drive enable |
| pb_din | input | 16 | Data lines in |
| pb_rd | output | 1 | Read strobe |
| pb_wr | output | 1 | Write strobe |
| pb_alh | output | 1 | High address latch strobe |
| pb_all | output | 1 | Low address latch strobe |

## Verification
The bench counts every phase of every cycle from the pins and compares it with counts derived from the encodings. It targets the asymmetric hold encoding, including a read with zero hold: an engine that treated reads like writes would stretch that cycle by one clock. Mode 2 is checked for two latch phases in high-then-low order, since a swapped or missing phase would feed the wrong byte to the external latch. The bench also checks increment wrap from 3FFF and decrement wrap from 0 with the chip-select bits preserved. A carry leaking into bit 14 would enable the wrong device. Both polarity settings are run. A request and an address load are injected mid-cycle, where a careless engine would restart or retarget the bus.

// File: rtl/pbus_master.sv
module pbus_master #(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_setup,
  input  logic [3:0]        cfg_strobe,
  input  logic [1:0]        cfg_hold,
  input  logic [1:0]        cfg_mux,
  input  logic              cfg_wide,
  input  logic [1:0]        cfg_step,
  input  logic [1:0]        cfg_csfn,
  input  logic              cfg_pol_rd,
  input  logic              cfg_pol_wr,
  input  logic              cfg_pol_cs1,
  input  logic              cfg_pol_cs2,
  input  logic              cfg_pol_al,
  input  logic              cfg_irq_en,
  input  logic              addr_wr,
  input  logic [ADDR_W+1:0] addr_wdata,
  output logic [ADDR_W+1:0] addr_q,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [15:0]       req_wdata,
  output logic [15:0]       rd_data,
  output logic              rd_valid,
  output logic              busy,
  output logic              irq,
  output logic              err,
  output logic [ADDR_W-1:0] pb_addr,
  output logic              pb_cs1,
  output logic              pb_cs2,
  output logic [15:0]       pb_dout,
  output logic              pb_doe,
  input  logic [15:0]       pb_din,
  output logic              pb_rd,
  output logic              pb_wr,
  output logic              pb_alh,
  output logic              pb_all
);
  // ADDR_W must lie in 9..16 for the byte-split latch formats.
  localparam int AR_W = ADDR_W + 2;

  typedef enum logic [2:0] {S_IDLE, S_ALH, S_ALL, S_SETUP, S_STROBE, S_HOLD} state_t;

  state_t      st, nxt_st, first_st;
  logic [3:0]  cnt, nxt_cnt;
  logic        is_wr;
  logic [15:0] wdat;
  logic [ADDR_W-1:0] a_step;

  wire start   = req_valid && (st == S_IDLE);
  wire last    = (cnt == 4'd0);
  wire no_hold = !is_wr && (cfg_hold == 2'd0);
  wire done    = last && ((st == S_STROBE && no_hold) || st == S_HOLD);
  wire lat     = (st == S_ALH) || (st == S_ALL);
  wire dphase  = (st == S_SETUP) || (st == S_STROBE) || (st == S_HOLD);
  wire [15:0] a16 = 16'(addr_q[ADDR_W-1:0]);

  assign busy = (st != S_IDLE);

  always_comb begin
    case (cfg_mux)
      2'd0:    first_st = S_SETUP;
      2'd2:    first_st = S_ALH;
      default: first_st = S_ALL;
    endcase
  end

  always_comb begin
    nxt_st  = st;
    nxt_cnt = cnt;
    if (st == S_IDLE) begin
      if (start) begin
        nxt_st  = first_st;
        nxt_cnt = {2'b00, cfg_setup};
      end
    end else if (!last) begin
      nxt_cnt = cnt - 4'd1;
    end else begin
      case (st)
        S_ALH:    begin nxt_st = S_ALL;    nxt_cnt = {2'b00, cfg_setup}; end
        S_ALL:    begin nxt_st = S_SETUP;  nxt_cnt = {2'b00, cfg_setup}; end
        S_SETUP:  begin nxt_st = S_STROBE; nxt_cnt = cfg_strobe;         end
        S_STROBE: begin
          if (no_hold) nxt_st = S_IDLE;
          else begin
            nxt_st  = S_HOLD;
            nxt_cnt = is_wr ? {2'b00, cfg_hold} : {2'b00, cfg_hold - 2'd1};
          end
        end
        default:  nxt_st = S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (cfg_step)
      2'd1:    a_step = addr_q[ADDR_W-1:0] + 1'b1;
      2'd2:    a_step = addr_q[ADDR_W-1:0] - 1'b1;
      default: a_step = addr_q[ADDR_W-1:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      is_wr    <= 1'b0;
      wdat     <= '0;
      addr_q   <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
      irq      <= 1'b0;
      err      <= 1'b0;
    end else begin
      st       <= nxt_st;
      cnt      <= nxt_cnt;
      rd_valid <= done && !is_wr;
      irq      <= done && cfg_irq_en;
      if (req_valid && busy) err <= 1'b1;
      if (start) begin
        is_wr <= req_write;
        wdat  <= req_wdata;
      end
      if (addr_wr && !busy) addr_q <= addr_wdata;
      else if (done)        addr_q <= {addr_q[AR_W-1:ADDR_W], a_step};
      if (st == S_STROBE && last && !is_wr)
        rd_data <= cfg_wide ? pb_din : {8'h00, pb_din[7:0]};
    end
  end

  logic [15:0] lat_word;
  always_comb begin
    if (st == S_ALH)        lat_word = a16 >> 8;
    else if (cfg_mux == 2'd3) lat_word = a16;
    else                    lat_word = {8'h00, a16[7:0]};
  end

  wire [15:0] data_word = cfg_wide ? wdat : {8'h00, wdat[7:0]};
  wire        drive_dat = dphase && is_wr;

  assign pb_doe  = lat || drive_dat;
  assign pb_dout = lat ? lat_word : (drive_dat ? data_word : 16'h0000);

  always_comb begin
    case (cfg_mux)
      2'd0:    pb_addr = addr_q[ADDR_W-1:0];
      2'd1:    pb_addr = {addr_q[ADDR_W-1:8], 8'h00};
      default: pb_addr = '0;
    endcase
  end

  wire rd_act = (st == S_STROBE) && !is_wr;
  wire wr_act = (st == S_STROBE) && is_wr;

  assign pb_rd  = rd_act ~^ cfg_pol_rd;
  assign pb_wr  = wr_act ~^ cfg_pol_wr;
  assign pb_alh = (st == S_ALH) ~^ cfg_pol_al;
  assign pb_all = (st == S_ALL) ~^ cfg_pol_al;
  assign pb_cs2 = (cfg_csfn == 2'd0) ? addr_q[AR_W-1]
                                     : ((busy && addr_q[AR_W-1]) ~^ cfg_pol_cs2);
  assign pb_cs1 = (cfg_csfn <= 2'd1) ? addr_q[AR_W-2]
                                     : ((busy && addr_q[AR_W-2]) ~^ cfg_pol_cs1);
endmodule

module pbus_master_chk #(
  parameter int AR_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            irq,
  input logic            err,
  input logic            rd_valid,
  input logic            pb_rd,
  input logic            pb_wr,
  input logic            pb_alh,
  input logic            pb_all,
  input logic            pb_doe,
  input logic            cfg_pol_rd,
  input logic            cfg_pol_wr,
  input logic            cfg_pol_al,
  input logic [AR_W-1:0] addr_q
);
  wire rd_a  = (pb_rd  == cfg_pol_rd);
  wire wr_a  = (pb_wr  == cfg_pol_wr);
  wire alh_a = (pb_alh == cfg_pol_al);
  wire all_a = (pb_all == cfg_pol_al);

  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_a && wr_a));
  assert_strobe_in_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a || wr_a || alh_a || all_a) |-> busy);
  assert_latch_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (alh_a || all_a) |-> (pb_doe && !rd_a && !wr_a && !(alh_a && all_a)));
  assert_irq_at_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!busy && $past(busy)));
  assert_rdv_at_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!busy && $past(busy)));
  assert_err_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
  assert_addr_frozen_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(addr_q) || !busy));
endmodule

bind pbus_master pbus_master_chk #(.AR_W(ADDR_W + 2)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .irq(irq), .err(err),
  .rd_valid(rd_valid), .pb_rd(pb_rd), .pb_wr(pb_wr), .pb_alh(pb_alh),
  .pb_all(pb_all), .pb_doe(pb_doe), .cfg_pol_rd(cfg_pol_rd),
  .cfg_pol_wr(cfg_pol_wr), .cfg_pol_al(cfg_pol_al), .addr_q(addr_q)
);

// File: tb/tb_pbus_master.sv
`timescale 1ns/1ps
module tb_pbus_master;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [1:0] cfg_setup = 0, cfg_hold = 0, cfg_mux = 0, cfg_step = 0, cfg_csfn = 0;
  logic [3:0] cfg_strobe = 0;
  logic cfg_wide = 1, cfg_pol_rd = 1, cfg_pol_wr = 1, cfg_pol_cs1 = 1, cfg_pol_cs2 = 1;
  logic cfg_pol_al = 1, cfg_irq_en = 1;
  logic addr_wr = 0, req_valid = 0, req_write = 0;
  logic [15:0] addr_wdata = 0, req_wdata = 0, pb_din = 0;
  logic [15:0] addr_q, rd_data, pb_dout;
  logic [13:0] pb_addr;
  logic rd_valid, busy, irq, err, pb_cs1, pb_cs2, pb_doe, pb_rd, pb_wr, pb_alh, pb_all;

  pbus_master dut (.*);

  int n_chk = 0, n_fail = 0, n_done = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic wr;
    logic [4:0] n_alh, n_all, n_setup, n_strobe, n_hold;
    logic [15:0] lat_h, lat_l, pa, dout, rdata, addr_after;
    logic cs1, cs2, irqe;
  } exp_t;

  exp_t q[$];
  logic [15:0] m_addr = 0;

  // monitor: measures each cycle from the pins and compares with the queue head
  bit in_cyc = 0, order_bad = 0;
  int c_alh, c_all, c_setup, c_strobe, c_hold, c_tot;
  logic [15:0] s_lat_h, s_lat_l, s_pa, s_dout;
  logic s_cs1, s_cs2, s_doe;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!in_cyc && busy) begin
        in_cyc = 1; order_bad = 0;
        c_alh = 0; c_all = 0; c_setup = 0; c_strobe = 0; c_hold = 0; c_tot = 0;
      end
      if (in_cyc && busy) begin
        c_tot++;
        if (pb_alh == cfg_pol_al) begin
          if (c_all > 0) order_bad = 1;
          if (c_alh == 0) s_lat_h = pb_dout;
          c_alh++;
        end else if (pb_all == cfg_pol_al) begin
          if (c_all == 0) s_lat_l = pb_dout;
          c_all++;
        end else if (pb_rd == cfg_pol_rd || pb_wr == cfg_pol_wr) begin
          if (c_strobe == 0) begin
            s_pa = {2'b00, pb_addr}; s_dout = pb_dout; s_doe = pb_doe;
            s_cs1 = pb_cs1; s_cs2 = pb_cs2;
          end
          c_strobe++;
        end else if (c_strobe == 0) c_setup++;
        else c_hold++;
      end else if (in_cyc && !busy) begin
        in_cyc = 0;
        if (q.size() == 0) chk("R10", "unexpected bus cycle", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk("R1", "setup clocks", c_setup, e.n_setup);
          chk("R1", "latch-high clocks", c_alh, e.n_alh);
          chk("R1", "latch-low clocks", c_all, e.n_all);
          chk("R2", "strobe clocks", c_strobe, e.n_strobe);
          chk("R3", "hold clocks", c_hold, e.n_hold);
          chk("R10", "busy length", c_tot, e.n_alh + e.n_all + e.n_setup + e.n_strobe + e.n_hold);
          chk("R5", "latch order high-then-low", order_bad, 0);
          if (e.n_alh != 0) chk("R4", "high latch word", s_lat_h, e.lat_h);
          if (e.n_all != 0) chk("R4", "low latch word", s_lat_l, e.lat_l);
          chk("R4", "address pins", s_pa, e.pa);
          chk("R6", "data out at strobe", s_dout, e.dout);
          chk("R6", "data drive at strobe", s_doe, e.wr);
          chk("R8", "cs1 pin", s_cs1, e.cs1);
          chk("R8", "cs2 pin", s_cs2, e.cs2);
          chk("R11", "irq at end", irq, e.irqe);
          chk("R11", "rd_valid at end", rd_valid, !e.wr);
          if (!e.wr) chk("R6", "read data", rd_data, e.rdata);
          chk("R7", "address after cycle", addr_q, e.addr_after);
        end
        n_done++;
      end
    end
  end

  task automatic run_cycle(input bit wr, input logic [15:0] wd, input logic [15:0] din, input bit poke);
    exp_t e;
    int target;
    logic [13:0] a14;
    a14 = m_addr[13:0];
    e.wr = wr;
    e.n_setup = 5'(cfg_setup) + 5'd1;
    e.n_alh = (cfg_mux == 2) ? e.n_setup : 5'd0;
    e.n_all = (cfg_mux != 0) ? e.n_setup : 5'd0;
    e.n_strobe = 5'(cfg_strobe) + 5'd1;
    e.n_hold = wr ? 5'(cfg_hold) + 5'd1 : 5'(cfg_hold);
    e.lat_h = {2'b00, a14} >> 8;
    e.lat_l = (cfg_mux == 3) ? {2'b00, a14} : {8'h00, a14[7:0]};
    e.pa = (cfg_mux == 0) ? {2'b00, a14} : (cfg_mux == 1) ? {2'b00, a14[13:8], 8'h00} : 16'h0;
    e.dout = wr ? (cfg_wide ? wd : {8'h00, wd[7:0]}) : 16'h0;
    e.rdata = cfg_wide ? din : {8'h00, din[7:0]};
    case (cfg_step)
      2'd1: e.addr_after = {m_addr[15:14], a14 + 14'd1};
      2'd2: e.addr_after = {m_addr[15:14], a14 - 14'd1};
      default: e.addr_after = m_addr;
    endcase
    e.cs2 = (cfg_csfn == 0) ? m_addr[15] : (m_addr[15] ~^ cfg_pol_cs2);
    e.cs1 = (cfg_csfn <= 1) ? m_addr[14] : (m_addr[14] ~^ cfg_pol_cs1);
    e.irqe = cfg_irq_en;
    target = n_done + 1;
    q.push_back(e);
    m_addr = e.addr_after;
    @(negedge clk); req_valid = 1; req_write = wr; req_wdata = wd; pb_din = din;
    @(negedge clk); req_valid = 0;
    if (poke) begin
      repeat (2) @(negedge clk);
      req_valid = 1; req_write = !wr; addr_wr = 1; addr_wdata = 16'h1234;
      @(negedge clk); req_valid = 0; addr_wr = 0;
    end
    while (n_done < target) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic load_addr(input logic [15:0] v);
    @(negedge clk); addr_wr = 1; addr_wdata = v;
    @(negedge clk); addr_wr = 0;
    m_addr = v;
    chk("R7", "host address load", addr_q, v);
  endtask

  task automatic idle_levels(input string req);
    chk(req, "idle rd", pb_rd, !cfg_pol_rd);
    chk(req, "idle wr", pb_wr, !cfg_pol_wr);
    chk(req, "idle alh", pb_alh, !cfg_pol_al);
    chk(req, "idle all", pb_all, !cfg_pol_al);
    if (cfg_csfn >= 2) begin
      chk(req, "idle cs1", pb_cs1, !cfg_pol_cs1);
      chk(req, "idle cs2", pb_cs2, !cfg_pol_cs2);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog: got hang expected finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    cfg_csfn = 2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R13 reset state
    chk("R13", "busy", busy, 0);
    chk("R13", "irq", irq, 0);
    chk("R13", "rd_valid", rd_valid, 0);
    chk("R13", "err", err, 0);
    chk("R13", "addr_q", addr_q, 0);
    chk("R13", "pb_doe", pb_doe, 0);
    idle_levels("R13");

    // R1 R2 R3: minimum phases, separate address, 16-bit, increment, two chip selects
    load_addr(16'h4005);
    cfg_mux = 0; cfg_wide = 1; cfg_step = 1;
    run_cycle(1, 16'hA55A, 16'h0, 0);
    run_cycle(0, 16'h0, 16'hBEEF, 0);   // read with zero hold (R3)

    // R4 mode 1, 8-bit write, decrement, csfn 1 (R8)
    cfg_mux = 1; cfg_wide = 0; cfg_step = 2; cfg_csfn = 1;
    cfg_setup = 3; cfg_strobe = 5; cfg_hold = 3;
    load_addr(16'hC2AB);
    run_cycle(1, 16'h12C7, 16'h0, 0);

    // R5 mode 2 two latch phases, 8-bit read, raw address pins on cs (R8)
    cfg_mux = 2; cfg_csfn = 0; cfg_setup = 1; cfg_strobe = 2; cfg_hold = 2; cfg_step = 0;
    load_addr(16'h7F12);
    run_cycle(0, 16'h0, 16'h9C3D, 0);

    // R7 increment wrap, mode 3, 16-bit write
    cfg_mux = 3; cfg_wide = 1; cfg_step = 1; cfg_csfn = 2; cfg_setup = 0; cfg_strobe = 1; cfg_hold = 1;
    load_addr(16'hBFFF);
    run_cycle(1, 16'h3C5A, 16'h0, 0);

    // R7 decrement wrap, R11 irq disabled
    cfg_mux = 0; cfg_step = 2; cfg_irq_en = 0;
    load_addr(16'h8000);
    run_cycle(0, 16'h0, 16'h1357, 0);
    cfg_step = 3;
    run_cycle(1, 16'hFFFF, 16'h0, 0);   // step 3 holds
    cfg_irq_en = 1;

    // R9 all polarities active-low
    cfg_pol_rd = 0; cfg_pol_wr = 0; cfg_pol_cs1 = 0; cfg_pol_cs2 = 0; cfg_pol_al = 0;
    cfg_mux = 2; cfg_wide = 0; cfg_step = 1;
    @(negedge clk);
    idle_levels("R9");
    load_addr(16'hC123);
    run_cycle(0, 16'h0, 16'h00E4, 0);
    run_cycle(1, 16'h0077, 16'h0, 0);
    cfg_pol_rd = 1; cfg_pol_wr = 1; cfg_pol_cs1 = 1; cfg_pol_cs2 = 1; cfg_pol_al = 1;
    @(negedge clk);
    idle_levels("R9");

    // R12 request and address load while busy; longest phases (R1 R2 R3)
    cfg_mux = 0; cfg_wide = 1; cfg_setup = 3; cfg_strobe = 15; cfg_hold = 3; cfg_step = 1;
    load_addr(16'h0100);
    chk("R12", "err before", err, 0);
    run_cycle(1, 16'h8421, 16'h0, 1);
    chk("R12", "err sticky after request while busy", err, 1);
    chk("R12", "no second cycle", busy, 0);
    repeat (3) @(negedge clk);
    chk("R12", "still idle", busy, 0);
    chk("R12", "address load while busy ignored", addr_q, 16'h0101);
    chk("R12", "err stays set", err, 1);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule